// File: doc/BRIEF.md
# Oversampled SPI Slave with Shared Transaction Buffer

This block is a full-duplex SPI slave that lives entirely in the fast system clock domain. The SPI clock, chip select and MOSI are resynchronised and the SPI clock edges are recovered by comparing successive samples, so the block holds no logic clocked by the SPI clock. The SPI clock must run at no more than one eighth of the system clock with a duty cycle near 50%. A 64-byte buffer supplies the outgoing MISO bytes and is overwritten, byte for byte, by what arrives on MOSI.

Before a transaction the host loads the outgoing bytes through a simple write port while chip select is high. The master then pulls chip select low, clocks any number of bytes and releases chip select. The block then latches the number of whole bytes received and raises a done flag, and the host reads the received bytes back through the same port. The SPI mode, the receive bit order, the transmit bit order and an option that launches MISO half an SPI clock early in modes 0 and 2 are static inputs.

The control is a three-state machine. IDLE waits with chip select high and owns the host port. The transition IDLE to XFER is taken on a synchronised chip-select fall. XFER shifts bits. The transition XFER to WRAP is taken on a synchronised chip-select rise. WRAP latches the byte count and sets done, then always returns to IDLE. A soft reset forces any state to IDLE.

Top module: `spi_os_slave`

## Requirements
- R1: The mode input sets the SCLK idle level in mode[1] and the sampling edge in mode[0]. With mode[0]=0, MOSI is sampled on the first edge after the idle level. With mode[0]=1, MOSI is sampled on the second edge after the idle level, and MISO changes on the first.
- R2: With rx_lsb=0, the first received bit is stored in bit 7 of the buffer byte. With rx_lsb=1, the first received bit is stored in bit 0.
- R3: With tx_lsb=0, bit 7 of the buffer byte is sent first on MISO. With tx_lsb=1, bit 0 is sent first.
- R4: Received byte n of a transaction is written to buffer address n for n below 64. Later bytes are dropped and leave earlier bytes intact. rx_count never exceeds 64.
- R5: A chip-select rise after a transaction latches the number of whole bytes received into rx_count and sets done. done clears on done_ack while chip select is high, or on the next chip-select fall.
- R6: soft_rst clears the bit counters, the byte pointer and done, and returns the block to IDLE. The rest of a frame in progress is ignored and raises no done.
- R7: With early_miso=1 in modes 0 and 2, each MISO bit after the first changes on the sampling edge of the preceding bit, half an SPI clock before the normal shift edge.
- R8: MISO is 0 while chip select is high. In modes 1 and 3, MISO stays 0 after the chip-select fall until the first SCLK edge.
- R9: A final byte with fewer than 8 bits before the chip-select rise is not written and is not counted.
- R10: Host writes are ignored while a transaction is in progress, and host_rdata reads 0 then. While idle, host_rdata shows the buffer byte at host_addr.
- R11: In modes 0 and 2, the first MISO bit is driven shortly after the chip-select fall, before any SCLK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset |
| mode | input | 2 | SPI mode: bit 1 idle level, bit 0 sample on second edge |
| rx_lsb | input | 1 | Receive LSB-first when 1 |
| tx_lsb | input | 1 | Transmit LSB-first when 1 |
| early_miso | input | 1 | Half-clock early MISO in modes 0 and 2 |
| sclk | input | 1 | SPI clock from master |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Master-out data |
| miso | output | 1 | Slave-out data |
| host_we | input | 1 | Buffer write strobe |
| host_addr | input | 6 | Buffer address for host access |
| host_wdata | input | 8 | Buffer write data |
| host_rdata | output | 8 | Buffer read data, 0 while busy |
| done_ack | input | 1 | Clears done |
| done | output | 1 | Transaction complete flag |
| rx_count | output | 7 | Whole bytes received in last transaction |

## Verification
A corrupted bit counter appears at the ports as a received byte that is rotated in the buffer. Within the same byte it also appears as a MISO bit from the wrong position, so the byte readback after the chip-select rise exposes it. A byte pointer that runs past the buffer end shows up as an overwritten byte 0 and an rx_count above 64. A state machine stuck outside IDLE shows up within a few system clocks as host_rdata held at 0 and MISO not returning to idle. A faulty early-launch path is caught half an SPI clock after the first sampling edge, when MISO already shows, or still lacks, the second bit.

// File: rtl/spi_os_pkg.sv
package spi_os_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_WRAP = 2'd2
    } eng_state_t;
endpackage

// File: rtl/spi_os_edges.sv
// Resynchronises the SPI pins and recovers SCLK / CS edges.
module spi_os_edges #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic mosi_s
);
    // bit 0: sclk, bit 1: cs_n, bit 2: mosi
    localparam logic [2:0] PIN_RST = 3'b010;

    logic [2:0] chain [STAGES];
    logic [2:0] last;
    logic [2:0] cur;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= PIN_RST;
            last <= PIN_RST;
        end else begin
            chain[0] <= {mosi_i, cs_n_i, sclk_i};
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            last <= chain[STAGES-1];
        end
    end

    always_comb begin
        cur       = chain[STAGES-1];
        sclk_rise = cur[0] & ~last[0];
        sclk_fall = ~cur[0] & last[0];
        cs_fall   = ~cur[1] & last[1];
        cs_rise   = cur[1] & ~last[1];
        mosi_s    = cur[2];
    end
endmodule

// File: rtl/spi_os_buf.sv
// Byte buffer: one write port, two combinational read ports.
module spi_os_buf #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [7:0]    rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [7:0]    rdata_b
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_comb begin
        rdata_a = mem[raddr_a];
        rdata_b = mem[raddr_b];
    end
endmodule

// File: rtl/spi_os_engine.sv
// Transaction state machine and shift datapath.
module spi_os_engine
    import spi_os_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic [1:0]    mode,
    input  logic          rx_lsb,
    input  logic          tx_lsb,
    input  logic          early_miso,
    input  logic          sclk_rise,
    input  logic          sclk_fall,
    input  logic          cs_fall,
    input  logic          cs_rise,
    input  logic          mosi_s,
    input  logic          done_ack,
    input  logic [7:0]    tx_byte,
    output logic [AW-1:0] tx_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          miso,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] rx_count
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    eng_state_t    state, state_nx;
    logic [7:0]    rx_sh;
    logic [2:0]    rx_bits;
    logic [CW-1:0] byte_ptr;
    logic [2:0]    tx_bits;
    logic [CW-1:0] tx_ptr;
    logic          tx_live;

    logic cpol, cpha, lead, trail, samp, shft, adv, early_on, full;
    logic [7:0] rx_next;
    logic [2:0] bsel;

    always_comb begin
        cpol     = mode[1];
        cpha     = mode[0];
        lead     = cpol ? sclk_fall : sclk_rise;
        trail    = cpol ? sclk_rise : sclk_fall;
        samp     = cpha ? trail : lead;
        shft     = cpha ? lead : trail;
        early_on = early_miso & ~cpha;
        adv      = early_on ? samp : shft;
        full     = (byte_ptr == FULL);
        rx_next  = rx_lsb ? {mosi_s, rx_sh[7:1]} : {rx_sh[6:0], mosi_s};
        bsel     = tx_lsb ? tx_bits : ~tx_bits;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (cs_fall) state_nx = ST_XFER;
            ST_XFER: if (cs_rise) state_nx = ST_WRAP;
            ST_WRAP: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
        if (soft_rst) state_nx = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh    <= '0;
            rx_bits  <= '0;
            byte_ptr <= '0;
            tx_bits  <= '0;
            tx_ptr   <= '0;
            tx_live  <= 1'b0;
            done     <= 1'b0;
            rx_count <= '0;
        end else if (soft_rst) begin
            rx_bits  <= '0;
            byte_ptr <= '0;
            tx_bits  <= '0;
            tx_ptr   <= '0;
            tx_live  <= 1'b0;
            done     <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    rx_bits <= '0;
                    tx_bits <= '0;
                    tx_ptr  <= '0;
                    tx_live <= 1'b0;
                    if (done_ack) done <= 1'b0;
                    if (cs_fall) begin
                        byte_ptr <= '0;
                        done     <= 1'b0;
                        tx_live  <= ~cpha;
                    end
                end
                ST_XFER: begin
                    if (samp) begin
                        rx_sh   <= rx_next;
                        rx_bits <= rx_bits + 3'd1;
                        if (rx_bits == 3'd7 && !full) byte_ptr <= byte_ptr + CW'(1);
                    end
                    if (adv) begin
                        if (!tx_live) begin
                            tx_live <= 1'b1;
                        end else begin
                            tx_bits <= tx_bits + 3'd1;
                            if (tx_bits == 3'd7 && tx_ptr != FULL) tx_ptr <= tx_ptr + CW'(1);
                        end
                    end
                end
                ST_WRAP: begin
                    rx_count <= byte_ptr;
                    done     <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy    = (state != ST_IDLE);
        wr_en   = (state == ST_XFER) && samp && (rx_bits == 3'd7) && !full;
        wr_addr = byte_ptr[AW-1:0];
        wr_data = rx_next;
        tx_addr = tx_ptr[AW-1:0];
        miso    = (state == ST_XFER) && tx_live && (tx_ptr < FULL) ? tx_byte[bsel] : 1'b0;
    end
endmodule

// File: rtl/spi_os_slave.sv
module spi_os_slave #(
    parameter int DEPTH = 64,
    parameter int SYNC_STAGES = 2,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic [1:0]    mode,
    input  logic          rx_lsb,
    input  logic          tx_lsb,
    input  logic          early_miso,
    input  logic          sclk,
    input  logic          cs_n,
    input  logic          mosi,
    output logic          miso,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata,
    input  logic          done_ack,
    output logic          done,
    output logic [CW-1:0] rx_count
);
    logic sclk_rise, sclk_fall, cs_fall, cs_rise, mosi_s;
    logic eng_we, eng_busy, buf_we;
    logic [AW-1:0] eng_waddr, tx_addr, buf_waddr;
    logic [7:0] eng_wdata, tx_byte, host_raw, buf_wdata;

    spi_os_edges #(.STAGES(SYNC_STAGES)) u_edges (
        .clk(clk), .rst_n(rst_n),
        .sclk_i(sclk), .cs_n_i(cs_n), .mosi_i(mosi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .mosi_s(mosi_s)
    );

    spi_os_engine #(.DEPTH(DEPTH)) u_eng (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .mode(mode), .rx_lsb(rx_lsb), .tx_lsb(tx_lsb), .early_miso(early_miso),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .mosi_s(mosi_s),
        .done_ack(done_ack), .tx_byte(tx_byte), .tx_addr(tx_addr),
        .wr_en(eng_we), .wr_addr(eng_waddr), .wr_data(eng_wdata),
        .miso(miso), .busy(eng_busy), .done(done), .rx_count(rx_count)
    );

    always_comb begin
        buf_we     = eng_we | (host_we & ~eng_busy);
        buf_waddr  = eng_we ? eng_waddr : host_addr;
        buf_wdata  = eng_we ? eng_wdata : host_wdata;
        host_rdata = eng_busy ? 8'h00 : host_raw;
    end

    spi_os_buf #(.DEPTH(DEPTH)) u_buf (
        .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
        .raddr_a(host_addr), .rdata_a(host_raw),
        .raddr_b(tx_addr), .rdata_b(tx_byte)
    );
endmodule

// File: rtl/spi_os_chk.sv
module spi_os_chk #(
    parameter int DEPTH = 64,
    parameter int CW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          soft_rst,
    input logic          busy,
    input logic          miso,
    input logic          done,
    input logic          done_ack,
    input logic          wr_en,
    input logic [CW-1:0] rx_count
);
    p_idle_miso_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (miso == 1'b0));

    p_count_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CW'(DEPTH));

    p_soft_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!done && !busy));

    p_done_after_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_ack && !busy && !soft_rst) |=> !done);

    p_store_in_xfer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy);
endmodule

bind spi_os_slave spi_os_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .busy(eng_busy),
    .miso(miso), .done(done), .done_ack(done_ack), .wr_en(eng_we),
    .rx_count(rx_count)
);

// File: tb/sim_spi_os_slave.sv
`timescale 1ns/1ps
module sim_spi_os_slave;
    localparam int H = 8;
    localparam int NV = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 1'b0;
    logic [1:0] mode = 2'd0;
    logic rx_lsb = 1'b0, tx_lsb = 1'b0, early_miso = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso;
    logic host_we = 1'b0;
    logic [5:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic done_ack = 1'b0;
    logic done;
    logic [6:0] rx_count;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    spi_os_slave u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .mode(mode),
        .rx_lsb(rx_lsb), .tx_lsb(tx_lsb), .early_miso(early_miso),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .done_ack(done_ack), .done(done),
        .rx_count(rx_count)
    );

    // {mode, rx_lsb, tx_lsb, early, tx byte, mosi wire, expected stored, expected miso wire}
    localparam logic [36:0] VEC [NV] = '{
        {2'd0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C, 8'h3C, 8'hA5},
        {2'd1, 1'b0, 1'b0, 1'b0, 8'h5A, 8'hC3, 8'hC3, 8'h5A},
        {2'd2, 1'b0, 1'b0, 1'b0, 8'h96, 8'h0F, 8'h0F, 8'h96},
        {2'd3, 1'b0, 1'b0, 1'b0, 8'h81, 8'hF0, 8'hF0, 8'h81},
        {2'd0, 1'b1, 1'b0, 1'b0, 8'h12, 8'h01, 8'h80, 8'h12},
        {2'd3, 1'b0, 1'b1, 1'b0, 8'h01, 8'h55, 8'h55, 8'h80},
        {2'd1, 1'b1, 1'b1, 1'b0, 8'h0F, 8'h0E, 8'h70, 8'hF0},
        {2'd0, 1'b0, 1'b0, 1'b1, 8'hC6, 8'h33, 8'h33, 8'hC6},
        {2'd2, 1'b0, 1'b0, 1'b1, 8'h3A, 8'h81, 8'h81, 8'h3A}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        @(negedge clk);
        d = host_rdata;
    endtask

    task automatic ack();
        @(negedge clk); done_ack = 1'b1;
        @(negedge clk); done_ack = 1'b0;
    endtask

    task automatic shift_bit(input logic b, output logic m);
        if (!mode[0]) begin
            mosi = b; tick(H); m = miso;
            sclk = ~mode[1]; tick(H); sclk = mode[1];
        end else begin
            sclk = ~mode[1]; mosi = b; tick(H); m = miso;
            sclk = mode[1]; tick(H);
        end
    endtask

    task automatic shift_byte(input logic [7:0] w, output logic [7:0] got);
        for (int i = 7; i >= 0; i--) begin
            logic m;
            shift_bit(w[i], m);
            got[i] = m;
        end
    endtask

    task automatic cs_begin();
        sclk = mode[1]; tick(4);
        cs_n = 1'b0; tick(H);
    endtask

    task automatic cs_end();
        tick(H); cs_n = 1'b1; tick(H + 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] got, rd;
        logic m;
        tick(3);
        rst_n = 1'b1;
        tick(3);
        check("R5 reset done", {31'd0, done}, 32'd0);
        check("R8 reset miso", {31'd0, miso}, 32'd0);
        check("R5 reset count", {25'd0, rx_count}, 32'd0);

        // R1 R2 R3 R7: vector table
        for (int v = 0; v < NV; v++) begin
            logic [36:0] e;
            e = VEC[v];
            mode = e[36:35]; rx_lsb = e[34]; tx_lsb = e[33]; early_miso = e[32];
            sclk = mode[1]; tick(4);
            host_wr(6'd0, e[31:24]);
            cs_begin();
            shift_byte(e[23:16], got);
            cs_end();
            check($sformatf("R1 R3 miso wire vec %0d", v), {24'd0, got}, {24'd0, e[7:0]});
            check($sformatf("R5 count vec %0d", v), {25'd0, rx_count}, 32'd1);
            check($sformatf("R5 done vec %0d", v), {31'd0, done}, 32'd1);
            host_rd(6'd0, rd);
            check($sformatf("R1 R2 stored vec %0d", v), {24'd0, rd}, {24'd0, e[15:8]});
            ack();
            check($sformatf("R5 ack vec %0d", v), {31'd0, done}, 32'd0);
        end

        // R11 and R7: early launch versus normal in mode 0
        for (int pass = 0; pass < 2; pass++) begin
            mode = 2'd0; rx_lsb = 1'b0; tx_lsb = 1'b0; early_miso = pass[0];
            host_wr(6'd0, 8'hB4);
            cs_begin();
            check("R11 first bit at cs fall", {31'd0, miso}, 32'd1);
            sclk = 1'b1; tick(H / 2);
            check($sformatf("R7 after first sample early=%0d", pass), {31'd0, miso},
                  pass == 1 ? 32'd0 : 32'd1);
            tick(H / 2); sclk = 1'b0;
            for (int i = 0; i < 7; i++) shift_bit(1'b0, m);
            cs_end();
            ack();
        end

        // R8: modes 1 and 3 hold MISO at 0 until the first edge
        mode = 2'd1; early_miso = 1'b0;
        host_wr(6'd0, 8'hFF);
        cs_begin();
        check("R8 mode1 before first edge", {31'd0, miso}, 32'd0);
        sclk = 1'b1; tick(6);
        check("R8 mode1 after first edge", {31'd0, miso}, 32'd1);
        tick(H - 6); sclk = 1'b0; tick(H);
        for (int i = 0; i < 7; i++) shift_bit(1'b0, m);
        cs_end();
        check("R8 miso idle after cs rise", {31'd0, miso}, 32'd0);
        ack();

        // R4: overflow past 64 bytes
        mode = 2'd0;
        cs_begin();
        for (int i = 0; i < 66; i++) shift_byte(8'(i), got);
        cs_end();
        check("R4 count saturates", {25'd0, rx_count}, 32'd64);
        host_rd(6'd0, rd);
        check("R4 byte 0 not overwritten", {24'd0, rd}, 32'd0);
        host_rd(6'd63, rd);
        check("R4 last byte stored", {24'd0, rd}, 32'd63);
        ack();

        // R9: partial final byte
        host_wr(6'd1, 8'hEE);
        cs_begin();
        shift_byte(8'h5A, got);
        for (int i = 0; i < 4; i++) shift_bit(1'b1, m);
        cs_end();
        check("R9 partial not counted", {25'd0, rx_count}, 32'd1);
        host_rd(6'd1, rd);
        check("R9 partial not stored", {24'd0, rd}, 32'hEE);
        host_rd(6'd0, rd);
        check("R9 whole byte stored", {24'd0, rd}, 32'h5A);

        // R5: done cleared by next chip-select fall
        check("R5 done before fall", {31'd0, done}, 32'd1);
        cs_begin();
        check("R5 done cleared by cs fall", {31'd0, done}, 32'd0);

        // R10: host access blocked during transaction
        host_addr = 6'd0;
        tick(1);
        check("R10 readback zero while busy", {24'd0, host_rdata}, 32'd0);
        shift_byte(8'h11, got);
        cs_end();
        ack();
        host_wr(6'd10, 8'h11);
        cs_begin();
        host_wr(6'd10, 8'h77);
        shift_byte(8'h22, got);
        cs_end();
        host_rd(6'd10, rd);
        check("R10 busy write ignored", {24'd0, rd}, 32'h11);
        ack();

        // R6: soft reset mid-frame
        cs_begin();
        for (int i = 0; i < 3; i++) shift_bit(1'b1, m);
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        tick(1);
        check("R6 done clear after soft reset", {31'd0, done}, 32'd0);
        check("R6 idle miso after soft reset", {31'd0, miso}, 32'd0);
        for (int i = 0; i < 5; i++) shift_bit(1'b0, m);
        cs_end();
        check("R6 aborted frame raises no done", {31'd0, done}, 32'd0);
        cs_begin();
        shift_byte(8'hC3, got);
        cs_end();
        check("R6 count after restart", {25'd0, rx_count}, 32'd1);
        host_rd(6'd0, rd);
        check("R6 byte aligned after restart", {24'd0, rd}, 32'hC3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule